// File: doc/BRIEF.md
# JTAG Cross-Domain Packet Loader

This block is a test-data register on the JTAG scan chain. It takes fixed 33-bit command packets from an external debug host and hands each one to a consumer that runs on the core clock. The host scans a packet into a first shift stage on TCK and then commits it with the TAP update strobe. The commit copies the packet into a holding register and flips a request toggle. The toggle crosses into the core clock domain through a two-flop synchronizer.

On the core side, an edge on the synchronized toggle copies the holding register into a second 33-bit shift register. A small state machine then streams that register out bit-serially, bit 0 first, one bit per core cycle, with a valid strobe. A commit that arrives while a stream is still running waits in the holding register and is streamed after the current packet. If the instruction is deselected, a running stream stops and the core side returns to idle.

Top module: `jtag_pkt_loader`

## Requirements
- R1: While `tap_sel_i` and `tap_shift_i` are high, each TCK rising edge shifts `tdi_i` into bit 32 of the 33-bit capture stage and moves every other bit one place toward bit 0. `tdo_o` always shows bit 0 of that stage, so after 33 shifts the first bit scanned in sits at bit 0.
- R2: A TCK edge with `tap_sel_i` and `tap_capture_i` high clears the capture stage, so `tdo_o` reads 0 right after it.
- R3: A TCK edge with `tap_sel_i` and `tap_update_i` high commits the capture stage as one packet. That packet then appears on `ser_data_o`, bit 0 first, one bit per core cycle, while `ser_valid_o` is high.
- R4: For each packet that is not aborted, `ser_valid_o` is high for exactly 33 consecutive core cycles and then goes low for at least one cycle.
- R5: When no stream is pending or running, the last bit of a committed packet leaves within 37 core-clock rising edges of the update edge.
- R6: A commit that arrives while a stream is running is kept and streamed after that stream ends. Packets come out in commit order and none is lost.
- R7: When `tap_sel_i` falls during a stream, `ser_valid_o` goes low within 4 core cycles. The rest of that packet is dropped, and the packet is not sent again when the instruction is selected again.
- R8: Capture, shift and update strobes have no effect while `tap_sel_i` is low. The capture stage keeps its contents, so `tdo_o` does not change, and no packet is streamed.
- R9: While `rst_ni` is low, `ser_valid_o` and `tdo_o` are 0. After release, nothing is streamed until a new commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| tap_sel_i | input | 1 | This register's instruction is selected |
| tap_capture_i | input | 1 | TAP is in the capture state for the data register |
| tap_shift_i | input | 1 | TAP is in the shift state for the data register |
| tap_update_i | input | 1 | TAP is in the update state for the data register |
| tdi_i | input | 1 | Serial scan input |
| tdo_o | output | 1 | Serial scan output, bit 0 of the capture stage |
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| ser_data_o | output | 1 | Serial packet bit toward the sink |
| ser_valid_o | output | 1 | High while `ser_data_o` carries a packet bit |

## Verification
Packets with alternating bits, a single set bit at bit 0 and at bit 32, all ones and random values are scanned in with a slow TCK. These patterns separate a reversed bit order, an off-by-one in the shift count and stuck serial bits. One packet is scanned in with no capture before it, so that the old contents come out on TDO and show the direction of the scan stage. A fast-TCK pair commits a second packet mid-stream and tells a queued commit from a lost or reordered one. A deselect in the middle of a stream and strobes given while the instruction is deselected separate a clean abort, and an ignored strobe, from a stale packet sent again.

// File: rtl/jtag_pkt_loader_pkg.sv
package jtag_pkt_loader_pkg;
  localparam int unsigned PKT_W_DEF  = 33;
  localparam int unsigned SYNC_N_DEF = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } core_st_e;
endpackage

// File: rtl/jpl_tck_stage.sv
module jpl_tck_stage #(
  parameter int unsigned PKT_W = 33
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             capture_i,
  input  logic             shift_i,
  input  logic             update_i,
  input  logic             tdi_i,
  output logic             tdo_o,
  output logic [PKT_W-1:0] hold_o,
  output logic             req_tog_o
);
  logic [PKT_W-1:0] scan_q;
  logic [PKT_W-1:0] hold_q;
  logic             tog_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scan_q <= '0;
      hold_q <= '0;
      tog_q  <= 1'b0;
    end else if (sel_i) begin
      if (capture_i) begin
        scan_q <= '0;
      end else if (shift_i) begin
        scan_q <= {tdi_i, scan_q[PKT_W-1:1]};
      end
      // hold_q must stay put until the core side has copied it
      if (update_i) begin
        hold_q <= scan_q;
        tog_q  <= ~tog_q;
      end
    end
  end

  assign tdo_o     = scan_q[0];
  assign hold_o    = hold_q;
  assign req_tog_o = tog_q;
endmodule

// File: rtl/jpl_sync.sv
module jpl_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q[s] <= '0;
      end else if (s == 0) begin
        chain_q[s] <= d_i;
      end else begin
        chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/jpl_core_fsm.sv
module jpl_core_fsm
  import jtag_pkt_loader_pkg::*;
#(
  parameter int unsigned PKT_W = 33
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_tog_i,
  input  logic             sel_i,
  input  logic [PKT_W-1:0] hold_i,
  output logic             ser_data_o,
  output logic             ser_valid_o
);
  localparam int unsigned CNT_W = $clog2(PKT_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(PKT_W - 1);

  core_st_e         st_q;
  logic             ack_q;
  logic [PKT_W-1:0] out_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pend;

  assign pend = req_tog_i ^ ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ack_q <= 1'b0;
      out_q <= '0;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (pend) begin
            ack_q <= req_tog_i;
            // a commit seen while deselected is consumed, not sent
            if (sel_i) begin
              out_q <= hold_i;
              cnt_q <= '0;
              st_q  <= ST_SEND;
            end
          end
        end
        ST_SEND: begin
          if (!sel_i) begin
            st_q <= ST_IDLE;
          end else begin
            out_q <= out_q >> 1;
            if (cnt_q == LAST_BIT) begin
              st_q <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ser_valid_o = (st_q == ST_SEND);
  assign ser_data_o  = out_q[0];
endmodule

// File: rtl/jtag_pkt_loader.sv
module jtag_pkt_loader
  import jtag_pkt_loader_pkg::*;
#(
  parameter int unsigned PKT_W  = PKT_W_DEF,
  parameter int unsigned SYNC_N = SYNC_N_DEF
) (
  input  logic tck_i,
  input  logic tap_sel_i,
  input  logic tap_capture_i,
  input  logic tap_shift_i,
  input  logic tap_update_i,
  input  logic tdi_i,
  output logic tdo_o,
  input  logic clk_i,
  input  logic rst_ni,
  output logic ser_data_o,
  output logic ser_valid_o
);
  logic [PKT_W-1:0] hold;
  logic             tog_tck;
  logic             tog_core;
  logic             sel_core;

  jpl_tck_stage #(.PKT_W(PKT_W)) u_tck (
    .tck_i     (tck_i),
    .rst_ni    (rst_ni),
    .sel_i     (tap_sel_i),
    .capture_i (tap_capture_i),
    .shift_i   (tap_shift_i),
    .update_i  (tap_update_i),
    .tdi_i     (tdi_i),
    .tdo_o     (tdo_o),
    .hold_o    (hold),
    .req_tog_o (tog_tck)
  );

  jpl_sync #(.WIDTH(2), .STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({tap_sel_i, tog_tck}),
    .q_o    ({sel_core, tog_core})
  );

  jpl_core_fsm #(.PKT_W(PKT_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_tog_i   (tog_core),
    .sel_i       (sel_core),
    .hold_i      (hold),
    .ser_data_o  (ser_data_o),
    .ser_valid_o (ser_valid_o)
  );
endmodule

// File: rtl/jtag_pkt_loader_chk.sv
module jtag_pkt_loader_chk #(
  parameter int unsigned PKT_W = 33
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tck_i,
  input logic tap_sel_i,
  input logic tap_capture_i,
  input logic tdo_o,
  input logic ser_valid_o,
  input logic sel_core
);
  localparam int unsigned RUN_W = $clog2(PKT_W + 1) + 1;

  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_len <= '0;
    end else if (ser_valid_o) begin
      if (run_len != {RUN_W{1'b1}}) run_len <= run_len + 1'b1;
    end else begin
      run_len <= '0;
    end
  end

  p_run_max_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_valid_o |-> (run_len < RUN_W'(PKT_W)));

  p_full_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ser_valid_o) && $past(sel_core)) |-> (run_len == RUN_W'(PKT_W)));

  p_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_valid_o && !sel_core) |=> !ser_valid_o);

  p_capture_clear_r2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (tap_sel_i && tap_capture_i) |=> !tdo_o);
endmodule

bind jtag_pkt_loader jtag_pkt_loader_chk #(.PKT_W(PKT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tck_i         (tck_i),
  .tap_sel_i     (tap_sel_i),
  .tap_capture_i (tap_capture_i),
  .tdo_o         (tdo_o),
  .ser_valid_o   (ser_valid_o),
  .sel_core      (sel_core)
);

// File: tb/tb_jtag_pkt_loader.sv
`timescale 1ns/1ps
module tb_jtag_pkt_loader;
  localparam int W = 33;

  logic tck = 0, clk = 0, rst_ni = 0;
  logic sel = 0, cap = 0, sh = 0, upd = 0, tdi = 0;
  logic tdo, ser_data, ser_valid;

  int tck_half = 20;
  int n_checks = 0, n_errors = 0;
  int core_cyc = 0, idx = 0, n_done = 0, n_abort = 0;
  bit prev_done = 0, abort_ok = 0;
  logic [W-1:0] m_sr = '0;
  logic [W-1:0] exp_q[$];
  int lat_q[$];

  jtag_pkt_loader dut (
    .tck_i(tck), .tap_sel_i(sel), .tap_capture_i(cap), .tap_shift_i(sh),
    .tap_update_i(upd), .tdi_i(tdi), .tdo_o(tdo), .clk_i(clk), .rst_ni(rst_ni),
    .ser_data_o(ser_data), .ser_valid_o(ser_valid)
  );

  initial forever #4 clk = ~clk;
  initial begin #3; forever #(tck_half) tck = ~tck; end
  always @(posedge clk) core_cyc++;

  function automatic void chk(bit ok, string req, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endfunction

  // reference model of the serial side, compared on every core clock
  always @(negedge clk) if (rst_ni) begin
    if (ser_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R8 unexpected valid", 1, 0);
      end else begin
        if (idx == 0 && prev_done) chk(0, "R4 no gap between packets", 1, 0);
        prev_done = 0;
        chk(ser_data === exp_q[0][idx], "R3 serial bit", ser_data, exp_q[0][idx]);
        idx++;
        if (idx == W) begin
          if (lat_q[0] >= 0)
            chk(core_cyc - lat_q[0] <= 37, "R5 latency", core_cyc - lat_q[0], 37);
          void'(exp_q.pop_front());
          void'(lat_q.pop_front());
          idx = 0; n_done++; prev_done = 1;
        end
      end
    end else begin
      if (idx != 0) begin
        if (abort_ok) begin
          void'(exp_q.pop_front());
          void'(lat_q.pop_front());
          idx = 0; n_abort++; abort_ok = 0;
        end else begin
          chk(0, "R4 short run", idx, W);
          idx = 0;
        end
      end
      prev_done = 0;
    end
  end

  task automatic tck_cycle(bit c, bit s, bit u, bit d, string req = "R1");
    @(negedge tck);
    chk(tdo === m_sr[0], req, tdo, m_sr[0]);
    cap = c; sh = s; upd = u; tdi = d;
    @(posedge tck); #1;
    if (sel) begin
      if (c) m_sr = '0;
      else if (s) m_sr = {d, m_sr[W-1:1]};
      if (u) begin
        lat_q.push_back((exp_q.size() == 0 && idx == 0) ? core_cyc : -1);
        exp_q.push_back(m_sr);
      end
    end
  endtask

  task automatic set_sel(bit v);
    @(negedge tck); sel = v; cap = 0; sh = 0; upd = 0;
  endtask

  task automatic send_pkt(logic [W-1:0] p, bit with_cap);
    if (with_cap) tck_cycle(1, 0, 0, 0);
    tck_cycle(0, 0, 0, 0, "R2 tdo after capture");
    for (int i = 0; i < W; i++) tck_cycle(0, 1, 0, p[i]);
    tck_cycle(0, 0, 1, 0);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    chk(ser_valid === 1'b0, "R9 valid in reset", ser_valid, 0);
    chk(tdo === 1'b0, "R9 tdo in reset", tdo, 0);
    rst_ni = 1;
    sel = 1;
    repeat (40) @(negedge clk);
    chk(ser_valid === 1'b0 && n_done == 0, "R9 idle after reset", ser_valid, 0);

    // slow TCK, distinct patterns
    send_pkt(33'h0_5555_5555, 1); repeat (16) tck_cycle(0, 0, 0, 0); drain();
    send_pkt(33'h1_0000_0000, 1); repeat (16) tck_cycle(0, 0, 0, 0); drain();
    send_pkt(33'h0_0000_0001, 1); repeat (16) tck_cycle(0, 0, 0, 0); drain();
    send_pkt(33'h1_FFFF_FFFF, 1); repeat (16) tck_cycle(0, 0, 0, 0); drain();
    send_pkt({$urandom} % 2 == 0 ? {1'b0, $urandom} : {1'b1, $urandom}, 1);
    repeat (16) tck_cycle(0, 0, 0, 0); drain();
    // no capture: previous contents leave on TDO bit 0 first
    send_pkt({1'b0, $urandom}, 0); repeat (16) tck_cycle(0, 0, 0, 0); drain();
    chk(n_done == 6, "R3 packets delivered", n_done, 6);

    // strobes while deselected
    set_sel(0);
    for (int i = 0; i < 10; i++) tck_cycle(0, 1, 0, 1, "R8 tdo unchanged");
    tck_cycle(0, 0, 1, 0, "R8");
    tck_cycle(1, 0, 0, 0, "R8");
    tck_cycle(0, 0, 0, 0, "R8 tdo unchanged");
    set_sel(1);
    repeat (20) tck_cycle(0, 0, 0, 0, "R8 tdo unchanged");
    chk(n_done == 6, "R8 nothing streamed", n_done, 6);

    // fast TCK: second commit during a running stream
    tck_half = 5;
    repeat (2) @(negedge tck);
    send_pkt({1'b1, $urandom}, 1);
    for (int i = 0; i < 5; i++) tck_cycle(0, 1, 0, i[0]);
    tck_cycle(0, 0, 1, 0);
    repeat (20) tck_cycle(0, 0, 0, 0);
    drain();
    chk(n_done == 8, "R6 both packets in order", n_done, 8);
    tck_half = 20;
    repeat (2) @(negedge tck);

    // abort mid-stream
    send_pkt(33'h1_2345_6789, 1);
    repeat (3) tck_cycle(0, 0, 0, 0);
    chk(ser_valid === 1'b1, "R7 stream running before deselect", ser_valid, 1);
    abort_ok = 1;
    @(negedge tck); sel = 0;
    repeat (4) @(negedge clk);
    chk(ser_valid === 1'b0, "R7 valid low within 4 cycles", ser_valid, 0);
    repeat (60) @(negedge clk);
    chk(n_abort == 1 && exp_q.size() == 0, "R7 packet dropped", n_abort, 1);
    set_sel(1);
    repeat (100) @(negedge clk);
    chk(n_done == 8 && ser_valid === 1'b0, "R7 no resend", n_done, 8);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule